// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small accumulator processor. In each clock cycle it takes the accumulator byte, an operand byte, an operation code and the four incoming condition flags: carry, zero, overflow and negative. It computes a result byte and the next value of each flag. The result and the flags are registered, so the values for the inputs sampled at one rising edge appear on the outputs just after that edge.

Subtraction and compare have no subtractor of their own. They reuse the adder and feed it the bitwise inverse of the operand. Besides the usual add, subtract, compare, bitwise and shift functions, the block also has three fused operations. Each one first masks the accumulator with the operand and then shifts or rotates the masked value. Each fused operation has its own rule for the flags. A flag that an operation leaves alone is passed through from its input, so the surrounding datapath always writes all four flags back.

The design splits into a parameterised adder, a mask/shift unit and a top level that selects the operation and holds the output registers. The top level has no state sequence. Its "states" are just the ten operation codes, which the output-selection process decodes with a unique case.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_out` is 0 and all four flag outputs are 0.
- R2: The result and flags for the inputs present at a rising clock edge appear just after that edge. The outputs do not change between edges.
- R3: Add (`op_sel` = 0) gives `res_out` = (A + B + carry-in) mod 256. Carry takes bit 8 of that sum. Overflow is set when A and B have the same bit 7 and the result's bit 7 differs from it.
- R4: Subtract (`op_sel` = 1) is the add of R3 with B replaced by its bitwise inverse. Carry out 1 therefore means no borrow, and overflow follows the same sign rule applied to A and the inverted B.
- R5: Compare (`op_sel` = 2) leaves `res_out` equal to A. Carry is set when A >= B as unsigned numbers. Zero and negative come from A - B. Overflow keeps its input value.
- R6: Bitwise AND, OR and XOR (`op_sel` = 3, 4, 5) give A&B, A|B and A^B. They update zero and negative, and keep carry and overflow at their input values.
- R7: Shift left (`op_sel` = 6) acts on the operand byte B. The result is B shifted left one place with a 0 entering bit 0, and carry takes the old bit 7 of B. Overflow is kept.
- R8: Mask-then-shift-right (`op_sel` = 7) gives (A&B) >> 1. Carry takes bit 0 of A&B. Overflow is kept.
- R9: Mask-with-sign-carry (`op_sel` = 8) gives A&B, and carry takes bit 7 of A&B. Overflow is kept.
- R10: Mask-then-rotate (`op_sel` = 9) gives (A&B) >> 1 with the incoming carry placed in bit 7. Carry takes bit 0 of A&B. Overflow is set by the sign rule of R3 applied to the sum (A&B) + B.
- R11: For every operation from 0 to 9, zero is set exactly when the flag-source byte is 0, and negative copies its bit 7. The flag-source byte is the result, except for compare, where it is A - B.
- R12: Codes 10 to 15 are inert: `res_out` takes A, and every flag output takes its input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code (0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 shift left, 7 mask+shift right, 8 mask+sign carry, 9 mask+rotate) |
| acc_in | input | 8 | Accumulator byte A |
| opnd_in | input | 8 | Operand byte B |
| c_in | input | 1 | Incoming carry |
| z_in | input | 1 | Incoming zero flag |
| v_in | input | 1 | Incoming overflow flag |
| n_in | input | 1 | Incoming negative flag |
| res_out | output | 8 | Registered result byte |
| c_out | output | 1 | Registered carry |
| z_out | output | 1 | Registered zero |
| v_out | output | 1 | Registered overflow |
| n_out | output | 1 | Registered negative |

## Verification
Every result and every flag is due exactly one rising edge after its operands are presented. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, half a period after the capturing edge. A directed latency test reads the outputs once just before the capturing edge, where they must still show the previous value, and once after it. The reset check holds live operands on the inputs while reset is asserted, so an output that leaks through during reset is caught.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_MSR  = 4'd7,
        OP_MSC  = 4'd8,
        OP_MRR  = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic v;
        logic n;
    } alu_flags_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ovf
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        sum  = wide[W-1:0];
        co   = wide[W];
        ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] y,
    output logic         cy
);
    logic [W-1:0] masked;

    always_comb begin
        masked = a & b;
        y      = masked;
        cy     = ci;
        unique case (op)
            OP_AND: y = masked;
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_SHL: begin
                y  = {b[W-2:0], 1'b0};
                cy = b[W-1];
            end
            OP_MSR: begin
                y  = {1'b0, masked[W-1:1]};
                cy = masked[0];
            end
            OP_MSC: begin
                y  = masked;
                cy = masked[W-1];
            end
            OP_MRR: begin
                y  = {ci, masked[W-1:1]};
                cy = masked[0];
            end
            default: begin
                y  = masked;
                cy = ci;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] op_sel,
    input  logic [W-1:0]  acc_in,
    input  logic [W-1:0]  opnd_in,
    input  logic          c_in,
    input  logic          z_in,
    input  logic          v_in,
    input  logic          n_in,
    output logic [W-1:0]  res_out,
    output logic          c_out,
    output logic          z_out,
    output logic          v_out,
    output logic          n_out
);
    localparam int NUM_OPS = 10;

    alu_op_e      op;
    logic         op_known;
    logic [W-1:0] add_b;
    logic         add_ci;
    logic [W-1:0] add_sum;
    logic         add_co;
    logic         add_ovf;
    logic [W-1:0] bit_y;
    logic         bit_c;
    logic [W-1:0] rr_sum;
    logic         rr_co;
    logic         rr_ovf;
    logic [W-1:0] res_d;
    logic [W-1:0] flag_src;
    alu_flags_t   flg_d;
    alu_flags_t   flg_q;
    logic [W-1:0] res_q;

    assign op       = alu_op_e'(op_sel);
    assign op_known = (int'(op_sel) < NUM_OPS);

    // Subtract and compare feed the inverted operand to the shared adder
    assign add_b  = (op == OP_ADD) ? opnd_in : ~opnd_in;
    assign add_ci = (op == OP_CMP) ? 1'b1 : c_in;

    alu8_adder #(.W(W)) u_main_add (
        .a   (acc_in),
        .b   (add_b),
        .ci  (add_ci),
        .sum (add_sum),
        .co  (add_co),
        .ovf (add_ovf)
    );

    // Overflow source for the mask-then-rotate operation
    alu8_adder #(.W(W)) u_rot_add (
        .a   (acc_in & opnd_in),
        .b   (opnd_in),
        .ci  (1'b0),
        .sum (rr_sum),
        .co  (rr_co),
        .ovf (rr_ovf)
    );

    alu8_bitops #(.W(W)) u_bits (
        .op (op),
        .a  (acc_in),
        .b  (opnd_in),
        .ci (c_in),
        .y  (bit_y),
        .cy (bit_c)
    );

    // Output selection
    always_comb begin
        res_d    = acc_in;
        flag_src = acc_in;
        flg_d    = '{c: c_in, z: z_in, v: v_in, n: n_in};
        if (op_known) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    res_d   = add_sum;
                    flg_d.c = add_co;
                    flg_d.v = add_ovf;
                end
                OP_CMP: begin
                    res_d   = acc_in;
                    flg_d.c = add_co;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    res_d = bit_y;
                end
                OP_SHL, OP_MSR, OP_MSC: begin
                    res_d   = bit_y;
                    flg_d.c = bit_c;
                end
                OP_MRR: begin
                    res_d   = bit_y;
                    flg_d.c = bit_c;
                    flg_d.v = rr_ovf;
                end
                default: res_d = acc_in;
            endcase
            flag_src = (op == OP_CMP) ? add_sum : res_d;
            flg_d.z  = (flag_src == '0);
            flg_d.n  = flag_src[W-1];
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else begin
            res_q <= res_d;
            flg_q <= flg_d;
        end
    end

    assign res_out = res_q;
    assign c_out   = flg_q.c;
    assign z_out   = flg_q.z;
    assign v_out   = flg_q.v;
    assign n_out   = flg_q.n;

    // R5: compare leaves the accumulator value on the result
    a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd2) |=> (res_out == $past(acc_in)));

    // R5: compare carry is the unsigned greater-or-equal test
    a_r5_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd2) |=> (c_out == ($past(acc_in) >= $past(opnd_in))));

    // R6: bitwise operations pass carry and overflow through
    a_r6_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd3 || op_sel == 4'd4 || op_sel == 4'd5)
        |=> (c_out == $past(c_in) && v_out == $past(v_in)));

    // R11: zero and negative follow the registered result outside compare
    a_r11_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel < 4'd10 && op_sel != 4'd2)
        |=> (z_out == (res_out == '0) && n_out == res_out[W-1]));

    // R12: inert codes pass accumulator and flags through
    a_r12_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd10) |=> (res_out == $past(acc_in) && c_out == $past(c_in)
            && z_out == $past(z_in) && v_out == $past(v_in) && n_out == $past(n_in)));

    // R7: shift left carry is the old top bit of the operand
    a_r7_shl_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd6) |=> (c_out == $past(opnd_in[W-1])));
endmodule

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
    localparam real TCK   = 8.0;
    localparam int  NVEC  = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       c_in = 1'b0, z_in = 1'b0, v_in = 1'b0, n_in = 1'b0;
    logic [7:0] res_out;
    logic       c_out, z_out, v_out, n_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    alu8_core u_alu8_core (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in),
        .opnd_in(opnd_in), .c_in(c_in), .z_in(z_in), .v_in(v_in), .n_in(n_in),
        .res_out(res_out), .c_out(c_out), .z_out(z_out), .v_out(v_out), .n_out(n_out)
    );

    // {op, A, B, flags in (c z v n), expected result, expected flags (c z v n)}
    localparam logic [35:0] VECS [NVEC] = '{
        {4'd0, 8'h50, 8'h50, 4'b0000, 8'hA0, 4'b0011}, // R3 signed overflow
        {4'd0, 8'hFF, 8'h01, 4'b0000, 8'h00, 4'b1100}, // R3 carry out, zero
        {4'd0, 8'h10, 8'h20, 4'b1000, 8'h31, 4'b0000}, // R3 carry in
        {4'd1, 8'h50, 8'h10, 4'b1000, 8'h40, 4'b1000}, // R4 no borrow
        {4'd1, 8'h00, 8'h01, 4'b1000, 8'hFF, 4'b0001}, // R4 borrow
        {4'd1, 8'h80, 8'h01, 4'b1000, 8'h7F, 4'b1010}, // R4 overflow
        {4'd2, 8'h40, 8'h40, 4'b0010, 8'h40, 4'b1110}, // R5 equal, V kept
        {4'd2, 8'h10, 8'h20, 4'b0000, 8'h10, 4'b0001}, // R5 less than
        {4'd3, 8'hF0, 8'h0F, 4'b1010, 8'h00, 4'b1110}, // R6 AND keeps C V
        {4'd4, 8'h80, 8'h01, 4'b0000, 8'h81, 4'b0001}, // R6 OR
        {4'd5, 8'hAA, 8'hAA, 4'b0001, 8'h00, 4'b0100}, // R6 XOR
        {4'd6, 8'h00, 8'h81, 4'b0000, 8'h02, 4'b1000}, // R7 shift operand
        {4'd7, 8'hFF, 8'h03, 4'b0000, 8'h01, 4'b1000}, // R8 carry from bit 0
        {4'd7, 8'h0F, 8'hF0, 4'b1000, 8'h00, 4'b0100}, // R8 zero
        {4'd8, 8'hC3, 8'h81, 4'b0000, 8'h81, 4'b1001}, // R9 sign carry
        {4'd9, 8'hFF, 8'h80, 4'b1000, 8'hC0, 4'b0011}, // R10 rotate, overflow
        {4'd9, 8'h03, 8'h03, 4'b0000, 8'h01, 4'b1000}, // R10 carry from bit 0
        {4'd12, 8'h5A, 8'h33, 4'b1011, 8'h5A, 4'b1011} // R12 inert code
    };

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3, 4'd4, 4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            4'd9: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [3:0] f);
        op_sel = op; acc_in = a; opnd_in = b;
        {c_in, z_in, v_in, n_in} = f;
    endtask

    initial begin
        // R1: reset holds outputs at zero with live inputs present
        drive(4'd0, 8'h7F, 8'h01, 4'b1111);
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {res_out, c_out, z_out, v_out, n_out}, 12'h000);
        rst_n = 1'b1;

        // Table walk: drive on falling edge, sample after one rising edge
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i][35:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:12]);
            @(negedge clk);
            check(tag_of(VECS[i][35:32]), "vector", {res_out, c_out, z_out, v_out, n_out},
                  {VECS[i][11:4], VECS[i][3:0]});
        end

        // R2: output changes only at the capturing edge
        @(negedge clk);
        drive(4'd0, 8'h01, 8'h01, 4'b0000);
        @(negedge clk);
        check("R2", "settled", {res_out, c_out, z_out, v_out, n_out}, {8'h02, 4'b0000});
        drive(4'd0, 8'h7F, 8'h01, 4'b0000);
        #1;
        check("R2", "before edge", {res_out, c_out, z_out, v_out, n_out}, {8'h02, 4'b0000});
        @(negedge clk);
        check("R3", "after edge", {res_out, c_out, z_out, v_out, n_out}, {8'h80, 4'b0011});

        // R11: compare zero and negative come from the difference, not from A
        drive(4'd2, 8'h00, 8'h01, 4'b0100);
        @(negedge clk);
        check("R11", "cmp flags from difference", {res_out, c_out, z_out, v_out, n_out},
              {8'h00, 4'b0001});

        // R12: highest inert code keeps flags including zero clear on a zero A
        drive(4'd15, 8'h00, 8'hFF, 4'b0000);
        @(negedge clk);
        check("R12", "inert code 15", {res_out, c_out, z_out, v_out, n_out}, {8'h00, 4'b0000});

        // R1: asynchronous reset clears outputs mid-run
        drive(4'd4, 8'hF0, 8'h0F, 4'b1111);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "reset mid-run", {res_out, c_out, z_out, v_out, n_out}, 12'h000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule